// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the combinational arithmetic and logic stage of a small 8-bit controller datapath. Each cycle it takes the accumulator value, a second operand already fetched by the surrounding logic, the current carry and nibble carry, and a 4-bit operation code. It returns the 8-bit result together with new carry (CY), nibble carry (AC) and signed overflow (OV) values.

Each of the three flags comes with its own write-enable. The flag register file loads only the flags whose enable is high and keeps the others. Operand fetch, address generation, multiply, divide and all storage sit outside the block.

The operation set covers:
- binary add, add with carry and subtract with borrow;
- increment and decrement;
- bitwise AND, OR and XOR;
- clear and complement;
- rotates, with and without the carry;
- nibble swap;
- packed-BCD decimal adjust.

Top module: `acc_alu_top`

## Requirements
- R1: Opcode encoding on `op_i`: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 clear, 9 complement, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 nibble swap, 15 decimal adjust. For add (carry-in 0) and add-with-carry (carry-in `cy_i`), `res_o` is the low 8 bits of the sum. `cy_o` is the carry out of bit 7, `ac_o` is the carry out of bit 3, and `ov_o` is set when the signed sum falls outside -128..127.
- R2: Subtract-with-borrow gives `acc_i - src_i - cy_i` modulo 256. `cy_o` is the borrow into bit 7, `ac_o` is the borrow into bit 3, and `ov_o` is set when exactly one of bit 6 and bit 7 needs a borrow (for example 80h-01h gives 7Fh with OV=1).
- R3: Increment and decrement wrap modulo 256 (00h-1 gives FFh, FFh+1 gives 00h) and raise no flag write-enable.
- R4: AND, OR and XOR combine `acc_i` and `src_i` bit by bit (D3h AND 75h gives 51h). Clear gives 00h and complement gives the one's complement of `acc_i`. None of these raises a flag write-enable.
- R5: Rotate left moves bit 7 into bit 0, and rotate right moves bit 0 into bit 7. Nibble swap exchanges bits 7..4 with bits 3..0 (C3h gives 3Ch). None of these raises a flag write-enable.
- R6: Rotate left through carry puts `cy_i` into bit 0 and bit 7 into `cy_o` (C3h with CY=1 gives 87h, CY=1). Rotate right through carry puts `cy_i` into bit 7 and bit 0 into `cy_o` (C3h with CY=0 gives 61h, CY=1). Only the CY write-enable is raised.
- R7: Decimal adjust adds 06h when the low nibble exceeds 9 or `ac_i` is 1. It then adds 60h when the high nibble of that intermediate value exceeds 9, when `cy_i` is 1, or when the first step carried. `cy_o` is `cy_i` OR any carry out of either step, so it is never cleared. Only the CY write-enable is raised.
- R8: `cy_we_o`, `ac_we_o` and `ov_we_o` are all 1 for add, add-with-carry and subtract-with-borrow. For any flag whose enable is 0, `cy_o` equals `cy_i`, `ac_o` equals `ac_i` and `ov_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Source operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current nibble carry flag |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result byte |
| cy_o | output | 1 | New carry value |
| ac_o | output | 1 | New nibble carry value |
| ov_o | output | 1 | New overflow value |
| cy_we_o | output | 1 | Carry write-enable |
| ac_we_o | output | 1 | Nibble carry write-enable |
| ov_we_o | output | 1 | Overflow write-enable |

## Verification
The hardest case to reach is a decimal adjust where the low-nibble correction itself carries out of bit 7 and then forces the high correction. This happens only for accumulator values of FAh and above with a large low nibble or AC set.

The subtract overflow case, where a borrow reaches bit 6 but not bit 7 or the reverse, is also hard to hit by chance. The stimulus therefore places directed vectors at both points, with literal expected values (FAh, 9Ah, 80h-01h, 00h-01h). It then sweeps random operand, flag and opcode combinations against a behavioural model on every clock.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DATA_W = 2 * NIB_W;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CLR  = 4'd8,
    OP_CPL  = 4'd9,
    OP_RL   = 4'd10,
    OP_RLC  = 4'd11,
    OP_RR   = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWAP = 4'd14,
    OP_DA   = 4'd15
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned NIB = 4,
  localparam int unsigned W  = 2 * NIB
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c7_o,
  output logic         c3_o,
  output logic         ov_o
);
  logic [NIB:0] low_part;
  logic [W-1:0] mid_part;
  logic [W:0]   full_part;

  always_comb begin
    if (sub_i) begin
      low_part  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
      mid_part  = {1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]} - {{(W-1){1'b0}}, cin_i};
      full_part = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end else begin
      low_part  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
      mid_part  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
      full_part = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
  end

  assign sum_o = full_part[W-1:0];
  assign c7_o  = full_part[W];
  assign c3_o  = low_part[NIB];
  assign ov_o  = full_part[W] ^ mid_part[W-1];
endmodule

// File: rtl/acc_alu_shuffle.sv
module acc_alu_shuffle #(
  parameter int unsigned NIB = 4,
  localparam int unsigned W  = 2 * NIB
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  import acc_alu_pkg::*;

  logic [W-1:0] and_v, or_v, xor_v;

  for (genvar g = 0; g < W; g++) begin : g_bitwise
    assign and_v[g] = a_i[g] & b_i[g];
    assign or_v[g]  = a_i[g] | b_i[g];
    assign xor_v[g] = a_i[g] ^ b_i[g];
  end

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (alu_op_e'(op_i))
      OP_AND:  res_o = and_v;
      OP_OR:   res_o = or_v;
      OP_XOR:  res_o = xor_v;
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
      OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
      OP_RLC: begin
        res_o = {a_i[W-2:0], cy_i};
        cy_o  = a_i[W-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[W-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NIB-1:0], a_i[W-1:NIB]};
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int unsigned NIB = 4,
  localparam int unsigned W  = 2 * NIB
) (
  input  logic [W-1:0] a_i,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [W:0]     LOW_ADD   = (W+1)'(6);
  localparam logic [W:0]     HIGH_ADD  = (W+1)'(6) << NIB;

  logic         low_fix, high_fix;
  logic [W:0]   step1, step2;

  always_comb begin
    low_fix  = (a_i[NIB-1:0] > DIGIT_MAX) | ac_i;
    step1    = {1'b0, a_i} + (low_fix ? LOW_ADD : '0);
    high_fix = (step1[W-1:NIB] > DIGIT_MAX) | cy_i | step1[W];
    step2    = {1'b0, step1[W-1:0]} + (high_fix ? HIGH_ADD : '0);
  end

  assign res_o = step2[W-1:0];
  assign cy_o  = cy_i | step1[W] | step2[W];
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top #(
  parameter int unsigned NIB = 4,
  localparam int unsigned W  = 2 * NIB
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] src_i,
  input  logic         cy_i,
  input  logic         ac_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o,
  output logic         cy_we_o,
  output logic         ac_we_o,
  output logic         ov_we_o
);
  import acc_alu_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  alu_op_e      op;
  logic [W-1:0] as_b;
  logic         as_cin, as_sub;
  logic [W-1:0] as_sum, sh_res, da_res;
  logic         as_c7, as_c3, as_ov, sh_cy, da_cy;

  assign op = alu_op_e'(op_i);

  always_comb begin
    as_b   = src_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADDC: as_cin = cy_i;
      OP_SUBB: begin
        as_cin = cy_i;
        as_sub = 1'b1;
      end
      OP_INC:  as_b = ONE;
      OP_DEC: begin
        as_b   = ONE;
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  acc_alu_addsub #(.NIB(NIB)) u_addsub (
    .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .c7_o(as_c7), .c3_o(as_c3), .ov_o(as_ov)
  );

  acc_alu_shuffle #(.NIB(NIB)) u_shuffle (
    .op_i(op_i), .a_i(acc_i), .b_i(src_i), .cy_i(cy_i),
    .res_o(sh_res), .cy_o(sh_cy)
  );

  acc_alu_decadj #(.NIB(NIB)) u_decadj (
    .a_i(acc_i), .cy_i(cy_i), .ac_i(ac_i),
    .res_o(da_res), .cy_o(da_cy)
  );

  always_comb begin
    res_o   = sh_res;
    cy_o    = cy_i;
    ac_o    = ac_i;
    ov_o    = 1'b0;
    cy_we_o = 1'b0;
    ac_we_o = 1'b0;
    ov_we_o = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o   = as_sum;
        cy_o    = as_c7;
        ac_o    = as_c3;
        ov_o    = as_ov;
        cy_we_o = 1'b1;
        ac_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_INC, OP_DEC: res_o = as_sum;
      OP_RLC, OP_RRC: begin
        cy_o    = sh_cy;
        cy_we_o = 1'b1;
      end
      OP_DA: begin
        res_o   = da_res;
        cy_o    = da_cy;
        cy_we_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic [7:0] acc_i,
  input logic [7:0] src_i,
  input logic       cy_i,
  input logic       ac_i,
  input logic [3:0] op_i,
  input logic [7:0] res_o,
  input logic       cy_o,
  input logic       ac_o,
  input logic       ov_o,
  input logic       cy_we_o,
  input logic       ac_we_o,
  input logic       ov_we_o
);
  logic known;
  assign known = !$isunknown({acc_i, src_i, cy_i, ac_i, op_i});

  always_comb begin
    if (known) begin
      // R1 / R8: arithmetic writes all three flags
      if (op_i <= 4'd2)
        assert_arith_we_R8: assert (cy_we_o && ac_we_o && ov_we_o);
      // R3: increment/decrement write no flag
      if (op_i == 4'd3 || op_i == 4'd4)
        assert_incdec_noflag_R3: assert (!cy_we_o && !ac_we_o && !ov_we_o);
      // R4: logic group writes no flag, clear gives zero
      if (op_i >= 4'd5 && op_i <= 4'd9)
        assert_logic_noflag_R4: assert (!cy_we_o && !ac_we_o && !ov_we_o);
      if (op_i == 4'd8)
        assert_clear_zero_R4: assert (res_o == 8'h00);
      // R6: carry receives the bit shifted out
      if (op_i == 4'd11)
        assert_rlc_carry_R6: assert (cy_o == acc_i[7] && res_o[0] == cy_i);
      if (op_i == 4'd13)
        assert_rrc_carry_R6: assert (cy_o == acc_i[0] && res_o[7] == cy_i);
      // R7: decimal adjust never clears carry
      if (op_i == 4'd15 && cy_i)
        assert_da_sticky_R7: assert (cy_o);
      // R8: flags not written pass through
      if (!cy_we_o)
        assert_cy_pass_R8: assert (cy_o == cy_i);
      if (!ac_we_o)
        assert_ac_pass_R8: assert (ac_o == ac_i);
    end
  end
endmodule

bind acc_alu_top acc_alu_chk u_chk (
  .acc_i(acc_i), .src_i(src_i), .cy_i(cy_i), .ac_i(ac_i), .op_i(op_i),
  .res_o(res_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
  .cy_we_o(cy_we_o), .ac_we_o(ac_we_o), .ov_we_o(ov_we_o)
);

// File: tb/acc_alu_top_tb_top.sv
`timescale 1ns/1ps
module acc_alu_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] acc, src, res;
  logic       cy, ac, cyo, aco, ovo, cywe, acwe, ovwe;
  logic [3:0] op;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  acc_alu_top dut_i (
    .acc_i(acc), .src_i(src), .cy_i(cy), .ac_i(ac), .op_i(op),
    .res_o(res), .cy_o(cyo), .ac_o(aco), .ov_o(ovo),
    .cy_we_o(cywe), .ac_we_o(acwe), .ov_we_o(ovwe)
  );

  function automatic string tag_of(input int o);
    if (o <= 1) return "R1";
    if (o == 2) return "R2";
    if (o <= 4) return "R3";
    if (o <= 9) return "R4";
    if (o == 11 || o == 13) return "R6";
    if (o == 15) return "R7";
    return "R5";
  endfunction

  // behavioural reference: returns {we[2:0], ov, ac, cy, res[7:0]}
  function automatic logic [13:0] model(input int o, input int a, input int b,
                                        input int c, input int h);
    int r, rc, rh, rv, we, t, car, bw6;
    r = a; rc = c; rh = h; rv = 0; we = 0;
    case (o)
      0, 1: begin
        t = (o == 1) ? c : 0;
        r = a + b + t;
        rc = (r > 255);
        rh = ((a % 16) + (b % 16) + t) > 15;
        bw6 = ((a % 128) + (b % 128) + t) > 127;
        rv = rc ^ bw6;
        we = 7;
      end
      2: begin
        r = a - b - c;
        rc = (a < b + c);
        rh = ((a % 16) < (b % 16) + c);
        bw6 = ((a % 128) < (b % 128) + c);
        rv = rc ^ bw6;
        we = 7;
      end
      3: r = a + 1;
      4: r = a - 1;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 0;
      9: r = 255 - a;
      10: r = (a * 2) + (a / 128);
      11: begin r = (a * 2) + c; rc = a / 128; we = 1; end
      12: r = (a / 2) + (a % 2) * 128;
      13: begin r = (a / 2) + c * 128; rc = a % 2; we = 1; end
      14: r = (a % 16) * 16 + (a / 16);
      default: begin
        car = 0;
        t = a;
        if ((t % 16) > 9 || h == 1) t = t + 6;
        if (t > 255) car = 1;
        t = t % 256;
        if ((t / 16) > 9 || c == 1 || car == 1) t = t + 96;
        if (t > 255) car = 1;
        r = t;
        rc = (c == 1 || car == 1);
        we = 1;
      end
    endcase
    r = ((r % 256) + 256) % 256;
    return {3'(we), 1'(rv), 1'(rh), 1'(rc), 8'(r)};
  endfunction

  task automatic apply(input int o, input int a, input int b, input int c, input int h);
    @(posedge clk); #1;
    op = 4'(o); acc = 8'(a); src = 8'(b); cy = 1'(c); ac = 1'(h);
    @(negedge clk);
  endtask

  task automatic compare_model();
    logic [13:0] e, g;
    e = model(int'(op), int'(acc), int'(src), int'(cy), int'(ac));
    g = {ovwe, acwe, cywe, ovo, aco, cyo, res};
    checks++;
    if (e !== g) begin
      errors++;
      $display("FAIL %s/R8 op=%0d a=%02h b=%02h cy=%0b ac=%0b got=%04h exp=%04h",
               tag_of(int'(op)), op, acc, src, cy, ac, g, e);
    end
  endtask

  task automatic expect_lit(input string tag, input logic [7:0] er, input logic ec,
                            input logic ea, input logic ev);
    checks++;
    if (res !== er || cyo !== ec || aco !== ea || ovo !== ev) begin
      errors++;
      $display("FAIL %s got res=%02h cy=%0b ac=%0b ov=%0b exp res=%02h cy=%0b ac=%0b ov=%0b",
               tag, res, cyo, aco, ovo, er, ec, ea, ev);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 4'd0; acc = 8'h00; src = 8'h00; cy = 1'b0; ac = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_model();                       // reset state: 0+0, R1
    expect_lit("R1 idle", 8'h00, 1'b0, 1'b0, 1'b0);

    apply(0, 'h7F, 'h01, 0, 0); compare_model(); expect_lit("R1 ovf", 8'h80, 1'b0, 1'b1, 1'b1);
    apply(1, 'hFF, 'h00, 1, 0); compare_model(); expect_lit("R1 addc", 8'h00, 1'b1, 1'b1, 1'b0);
    apply(2, 'hC1, 'h40, 1, 0); compare_model(); expect_lit("R2 subb", 8'h80, 1'b0, 1'b0, 1'b0);
    apply(2, 'h80, 'h01, 0, 0); compare_model(); expect_lit("R2 ov", 8'h7F, 1'b0, 1'b1, 1'b1);
    apply(2, 'h00, 'h01, 0, 1); compare_model(); expect_lit("R2 borrow", 8'hFF, 1'b1, 1'b1, 1'b0);
    apply(4, 'h00, 'h00, 1, 1); compare_model(); expect_lit("R3 dec wrap", 8'hFF, 1'b1, 1'b1, 1'b0);
    apply(3, 'hFF, 'h00, 0, 0); compare_model(); expect_lit("R3 inc wrap", 8'h00, 1'b0, 1'b0, 1'b0);
    apply(5, 'hD3, 'h75, 1, 0); compare_model(); expect_lit("R4 and", 8'h51, 1'b1, 1'b0, 1'b0);
    apply(9, 'hC3, 'h00, 0, 1); compare_model(); expect_lit("R4 cpl", 8'h3C, 1'b0, 1'b1, 1'b0);
    apply(14, 'hC3, 'h00, 1, 0); compare_model(); expect_lit("R5 swap", 8'h3C, 1'b1, 1'b0, 1'b0);
    apply(12, 'hC3, 'h00, 0, 0); compare_model(); expect_lit("R5 rr", 8'hE1, 1'b0, 1'b0, 1'b0);
    apply(11, 'hC3, 'h00, 1, 0); compare_model(); expect_lit("R6 rlc", 8'h87, 1'b1, 1'b0, 1'b0);
    apply(13, 'hC3, 'h00, 0, 0); compare_model(); expect_lit("R6 rrc", 8'h61, 1'b1, 1'b0, 1'b0);
    apply(15, 'h9A, 'h00, 0, 0); compare_model(); expect_lit("R7 da 9A", 8'h00, 1'b1, 1'b0, 1'b0);
    apply(15, 'hFA, 'h00, 0, 0); compare_model(); expect_lit("R7 da FA", 8'h60, 1'b1, 1'b0, 1'b0);
    apply(15, 'h15, 'h00, 0, 1); compare_model(); expect_lit("R7 da ac", 8'h1B, 1'b0, 1'b1, 1'b0);
    apply(15, 'h12, 'h00, 1, 0); compare_model(); expect_lit("R7 da sticky", 8'h72, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      apply(i % 16, int'($urandom_range(255)), int'($urandom_range(255)),
            int'($urandom_range(1)), int'($urandom_range(1)));
      compare_model();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule